// File: doc/BRIEF.md
# Iterative Binary32 Floating-Point Divider

This block divides one IEEE 754 single-precision value by another. A caller presents a dividend and a divisor together with a one-cycle start strobe while the unit is idle. The unit then raises busy and works on the pair for a fixed number of clock cycles. When it finishes, it pulses done for one cycle, with the quotient and four exception flags.

Inside, each operand is classified and unpacked. Subnormal operands are renormalized so that their significands carry a leading one, and the result sign and a provisional exponent are formed. The 24-bit significands are then divided one quotient bit per clock by a non-restoring add/subtract loop of 26 steps. The leftover remainder becomes a sticky bit. A final combinational stage normalizes the quotient, detects overflow, and shifts tiny results right into the subnormal range one bit position at a time. It then rounds to nearest, with ties going to even. Special operand combinations take a separate path but keep the same latency.

Top module: `fp32_div_seq`

## Requirements
- R1: The sign bit of every non-NaN result equals the XOR of the two operand sign bits.
- R2: A start is accepted only while busy_o is low. Busy_o is high from the cycle after acceptance until the cycle in which done_o pulses. A start raised while busy_o is high is ignored and leaves no pending operation.
- R3: Done_o is high for exactly one cycle. That cycle comes 27 clock cycles after the edge that accepted the start.
- R4: For normal operands with an in-range result, the quotient is the exact ratio rounded to nearest-even, and all four flags are 0.
- R5: A subnormal operand (exponent field 0, nonzero fraction) is divided as its true value, not as zero.
- R6: Certain inputs give the quiet NaN word 0x7FC00000 with flag_invalid_o = 1: any NaN input (exponent field 255 with a nonzero fraction), 0/0, and infinity/infinity.
- R7: A finite nonzero dividend divided by zero gives a correctly signed infinity (exponent field 255, fraction 0) with flag_divzero_o = 1.
- R8: Infinity divided by a finite value gives a signed infinity. Zero divided by a nonzero value gives a signed zero, and so does a finite value divided by infinity. None of these cases sets any flag.
- R9: A result whose exponent reaches 255, either before or after rounding, gives a signed infinity with flag_overflow_o = 1.
- R10: A result below the smallest normal magnitude is rounded to the nearest subnormal (ties to even), possibly giving zero. A result whose biased exponent is below -23 gives signed zero. Flag_underflow_o is 1 exactly when the result was tiny before rounding and inexact.
- R11: After reset, busy_o, done_o, the result and all flags are 0.
- R12: The result and the flags hold their values from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, honoured only when idle |
| a_i | input | 32 | Dividend, binary32 |
| b_i | input | 32 | Divisor, binary32 |
| busy_o | output | 1 | High while a division is in flight |
| done_o | output | 1 | One-cycle pulse when the result is valid |
| quot_o | output | 32 | Quotient, binary32 |
| flag_invalid_o | output | 1 | Invalid operation |
| flag_divzero_o | output | 1 | Division of a finite nonzero value by zero |
| flag_overflow_o | output | 1 | Result overflowed to infinity |
| flag_underflow_o | output | 1 | Result tiny and inexact |

## Verification
A wrong add/subtract choice or a lost carry in the remainder corrupts quotient bits. This shows in quot_o in the done cycle of that same operation, usually in the low fraction bits or the rounding direction. A corrupted exponent or shift in the denormalize path shows as a wrong subnormal pattern or a wrong underflow flag on that same result. A miscount in the iteration counter shifts the done pulse away from cycle 27, or leaves busy stuck high. A bench reference built on exact 64-bit integer division catches both kinds of fault on every operation.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int WORD_W   = 1 + EXP_W + FRAC_W;
  localparam int MANT_W   = FRAC_W + 1;
  localparam int QUO_W    = FRAC_W + 3;
  localparam int REM_W    = MANT_W + 4;
  localparam int SEXP_W   = EXP_W + 4;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_ALL1 = (1 << EXP_W) - 1;
  localparam int LATENCY  = QUO_W + 1;

  typedef logic signed [SEXP_W-1:0] sexp_t;

  typedef struct packed {
    logic              sign;
    logic              is_nan;
    logic              is_inf;
    logic              is_zero;
    sexp_t             exp;
    logic [MANT_W-1:0] mant;
  } opnd_t;
endpackage

// File: rtl/fpdiv_unpack.sv
module fpdiv_unpack
  import fpdiv_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output opnd_t             op_o
);
  logic [EXP_W-1:0]  ef;
  logic [FRAC_W-1:0] ff;
  assign ef = word_i[WORD_W-2:FRAC_W];
  assign ff = word_i[FRAC_W-1:0];

  always_comb begin
    int lz;
    lz = FRAC_W;
    for (int i = 0; i < FRAC_W; i++) begin
      if (ff[i]) lz = FRAC_W - i;
    end
    op_o         = '0;
    op_o.sign    = word_i[WORD_W-1];
    op_o.is_nan  = (ef == EXP_W'(EXP_ALL1)) && (ff != '0);
    op_o.is_inf  = (ef == EXP_W'(EXP_ALL1)) && (ff == '0);
    op_o.is_zero = (ef == '0) && (ff == '0);
    if (ef == '0) begin
      op_o.mant = {1'b0, ff} << lz;
      op_o.exp  = sexp_t'(1 - lz);
    end else begin
      op_o.mant = {1'b1, ff};
      op_o.exp  = sexp_t'(ef);
    end
  end
endmodule

// File: rtl/fpdiv_nr_core.sv
module fpdiv_nr_core
  import fpdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [MANT_W-1:0] dvd_i,
  input  logic [MANT_W-1:0] dvs_i,
  output logic [QUO_W-1:0]  quo_o,
  output logic              sticky_o,
  output logic              fin_o
);
  localparam int CNT_W = $clog2(QUO_W + 1);
  typedef logic signed [REM_W-1:0] rem_t;

  rem_t             rem_q, dvs_q, base, nxt, corr;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_comb begin
    base     = (cnt_q == '0) ? rem_q : (rem_q <<< 1);
    nxt      = rem_q[REM_W-1] ? (base + dvs_q) : (base - dvs_q);
    corr     = rem_q[REM_W-1] ? (rem_q + dvs_q) : rem_q;
    sticky_o = (corr != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_o <= 1'b0;
      quo_o <= '0;
    end else if (load_i) begin
      rem_q <= rem_t'(dvd_i);
      dvs_q <= rem_t'(dvs_i);
      cnt_q <= '0;
      run_q <= 1'b1;
      fin_o <= 1'b0;
      quo_o <= '0;
    end else if (run_q) begin
      rem_q <= nxt;
      quo_o <= {quo_o[QUO_W-2:0], ~nxt[REM_W-1]};
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(QUO_W - 1)) begin
        run_q <= 1'b0;
        fin_o <= 1'b1;
      end
    end else begin
      fin_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fpdiv_round.sv
module fpdiv_round
  import fpdiv_pkg::*;
(
  input  logic              sign_i,
  input  sexp_t             exp_i,
  input  logic [QUO_W-1:0]  quo_i,
  input  logic              sticky_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic [QUO_W-1:0]         m;
  sexp_t                    e;
  logic                     st, tiny, g, r, lsb, up;
  logic [EXP_W-1:0]         efield;
  logic [EXP_W+FRAC_W-1:0]  mag;

  always_comb begin
    int sh;
    m      = quo_i;
    e      = exp_i;
    st     = sticky_i;
    tiny   = 1'b0;
    efield = '0;
    ovf_o  = 1'b0;
    unf_o  = 1'b0;
    g      = 1'b0;
    r      = 1'b0;
    lsb    = 1'b0;
    up     = 1'b0;
    mag    = '0;
    if (!m[QUO_W-1]) begin
      m = m << 1;
      e = e - sexp_t'(1);
    end
    sh = 1 - int'(e);
    if (e >= sexp_t'(EXP_ALL1)) begin
      mag   = {EXP_W'(EXP_ALL1), {FRAC_W{1'b0}}};
      ovf_o = 1'b1;
    end else if (e < -sexp_t'(FRAC_W)) begin
      mag   = '0;
      unf_o = 1'b1;
    end else begin
      if (e <= sexp_t'(0)) begin
        tiny = 1'b1;
        for (int i = 0; i <= FRAC_W; i++) begin
          if (i < sh) begin
            st = st | m[0];
            m  = m >> 1;
          end
        end
      end else begin
        efield = e[EXP_W-1:0];
      end
      g     = m[1];
      r     = m[0];
      lsb   = m[2];
      up    = g & (r | st | lsb);
      mag   = {efield, m[QUO_W-2:2]} + {{(EXP_W+FRAC_W-1){1'b0}}, up};
      ovf_o = (mag[EXP_W+FRAC_W-1:FRAC_W] == EXP_W'(EXP_ALL1));
      unf_o = tiny & (g | r | st);
    end
    word_o = {sign_i, mag};
  end
endmodule

// File: rtl/fp32_div_seq.sv
module fp32_div_seq
  import fpdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] quot_o,
  output logic              flag_invalid_o,
  output logic              flag_divzero_o,
  output logic              flag_overflow_o,
  output logic              flag_underflow_o
);
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  opnd_t oa, ob;
  fpdiv_unpack u_ua (.word_i(a_i), .op_o(oa));
  fpdiv_unpack u_ub (.word_i(b_i), .op_o(ob));

  logic              accept, rsign;
  logic              spec, spec_inv, spec_dz;
  logic [WORD_W-1:0] spec_word;

  assign accept = start_i & ~busy_o;
  assign rsign  = oa.sign ^ ob.sign;

  always_comb begin
    spec      = 1'b1;
    spec_inv  = 1'b0;
    spec_dz   = 1'b0;
    spec_word = '0;
    if (oa.is_nan || ob.is_nan || (oa.is_inf && ob.is_inf) || (oa.is_zero && ob.is_zero)) begin
      spec_word = QNAN;
      spec_inv  = 1'b1;
    end else if (oa.is_inf) begin
      spec_word = {rsign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (ob.is_zero) begin
      spec_word = {rsign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      spec_dz   = 1'b1;
    end else if (oa.is_zero || ob.is_inf) begin
      spec_word = {rsign, {(WORD_W-1){1'b0}}};
    end else begin
      spec = 1'b0;
    end
  end

  logic [QUO_W-1:0] quo;
  logic             sticky, fin;
  fpdiv_nr_core u_core (
    .clk(clk), .rst(rst), .load_i(accept),
    .dvd_i(oa.mant), .dvs_i(ob.mant),
    .quo_o(quo), .sticky_o(sticky), .fin_o(fin)
  );

  logic              sign_q, spec_q, spec_inv_q, spec_dz_q;
  sexp_t             exp_q;
  logic [WORD_W-1:0] spec_word_q, rnd_word;
  logic              rnd_ovf, rnd_unf;

  fpdiv_round u_round (
    .sign_i(sign_q), .exp_i(exp_q), .quo_i(quo), .sticky_i(sticky),
    .word_o(rnd_word), .ovf_o(rnd_ovf), .unf_o(rnd_unf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o           <= 1'b0;
      done_o           <= 1'b0;
      quot_o           <= '0;
      flag_invalid_o   <= 1'b0;
      flag_divzero_o   <= 1'b0;
      flag_overflow_o  <= 1'b0;
      flag_underflow_o <= 1'b0;
      sign_q           <= 1'b0;
      spec_q           <= 1'b0;
      spec_inv_q       <= 1'b0;
      spec_dz_q        <= 1'b0;
      spec_word_q      <= '0;
      exp_q            <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        busy_o      <= 1'b1;
        sign_q      <= rsign;
        spec_q      <= spec;
        spec_inv_q  <= spec_inv;
        spec_dz_q   <= spec_dz;
        spec_word_q <= spec_word;
        exp_q       <= oa.exp - ob.exp + sexp_t'(BIAS);
      end else if (busy_o && fin) begin
        busy_o           <= 1'b0;
        done_o           <= 1'b1;
        quot_o           <= spec_q ? spec_word_q : rnd_word;
        flag_invalid_o   <= spec_q & spec_inv_q;
        flag_divzero_o   <= spec_q & spec_dz_q;
        flag_overflow_o  <= ~spec_q & rnd_ovf;
        flag_underflow_o <= ~spec_q & rnd_unf;
      end
    end
  end
endmodule

// File: rtl/fp32_div_seq_chk.sv
module fp32_div_seq_chk
  import fpdiv_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] quot_o,
  input logic              flag_invalid_o,
  input logic              flag_divzero_o,
  input logic              flag_overflow_o,
  input logic              flag_underflow_o
);
  logic       sgn_q;
  logic [7:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sgn_q <= 1'b0;
      lat_q <= '0;
    end else if (start_i && !busy_o) begin
      sgn_q <= a_i[WORD_W-1] ^ b_i[WORD_W-1];
      lat_q <= 8'd1;
    end else if (busy_o && lat_q != 8'hFF) begin
      lat_q <= lat_q + 8'd1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R3
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst) done_o |-> lat_q == 8'(LATENCY + 1)); // R3
  AST_START_TAKES: assert property (@(posedge clk) disable iff (rst) (start_i && !busy_o) |=> busy_o); // R2
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst) done_o |-> !busy_o); // R2
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst) (done_o && !flag_invalid_o) |-> quot_o[WORD_W-1] == sgn_q); // R1
  AST_NAN_WORD: assert property (@(posedge clk) disable iff (rst) (done_o && flag_invalid_o) |-> quot_o == 32'h7FC0_0000); // R6
  AST_DZ_INF: assert property (@(posedge clk) disable iff (rst) (done_o && flag_divzero_o) |-> quot_o[WORD_W-2:0] == 31'h7F80_0000); // R7
  AST_NO_OVERFLOW_LEAK: assert property (@(posedge clk) disable iff (rst) (done_o && flag_overflow_o) |-> quot_o[WORD_W-2:0] == 31'h7F80_0000); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !done_o |=> (done_o || $stable(quot_o))); // R12
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) done_o |-> $countones({flag_invalid_o, flag_divzero_o, flag_overflow_o}) <= 1); // R6
endmodule

bind fp32_div_seq fp32_div_seq_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .a_i(a_i), .b_i(b_i),
  .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
  .flag_invalid_o(flag_invalid_o), .flag_divzero_o(flag_divzero_o),
  .flag_overflow_o(flag_overflow_o), .flag_underflow_o(flag_underflow_o)
);

// File: tb/fp32_div_seq_test.sv
module fp32_div_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        busy_o, done_o;
  logic [31:0] quot_o;
  logic        flag_invalid_o, flag_divzero_o, flag_overflow_o, flag_underflow_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_div_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .a_i(a_i), .b_i(b_i),
    .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
    .flag_invalid_o(flag_invalid_o), .flag_divzero_o(flag_divzero_o),
    .flag_overflow_o(flag_overflow_o), .flag_underflow_o(flag_underflow_o)
  );

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns {invalid, divzero, overflow, underflow, word}
  function automatic logic [35:0] ref_div(input logic [31:0] a, input logic [31:0] b);
    logic s;
    int ea, eb, p, e, sh;
    longint unsigned fa, fb, ma, mb, q, rm, kept, rb, half, mag;
    bit nan_a, nan_b, inf_a, inf_b, zer_a, zer_b, inex, up, ovf;
    s = a[31] ^ b[31];
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    fa = longint'(a[22:0]); fb = longint'(b[22:0]);
    nan_a = (ea == 255) && (fa != 0); nan_b = (eb == 255) && (fb != 0);
    inf_a = (ea == 255) && (fa == 0); inf_b = (eb == 255) && (fb == 0);
    zer_a = (ea == 0) && (fa == 0);   zer_b = (eb == 0) && (fb == 0);
    if (nan_a || nan_b || (inf_a && inf_b) || (zer_a && zer_b)) return {4'b1000, 32'h7FC0_0000};
    if (inf_a) return {4'b0000, s, 8'hFF, 23'd0};
    if (zer_b) return {4'b0100, s, 8'hFF, 23'd0};
    if (zer_a || inf_b) return {4'b0000, s, 31'd0};
    ma = (ea == 0) ? fa : (fa | 64'h80_0000); if (ea == 0) ea = 1;
    mb = (eb == 0) ? fb : (fb | 64'h80_0000); if (eb == 0) eb = 1;
    while (ma < 64'h80_0000) begin ma = ma << 1; ea--; end
    while (mb < 64'h80_0000) begin mb = mb << 1; eb--; end
    q  = (ma << 39) / mb;
    rm = (ma << 39) % mb;
    p  = (q >= (64'd1 << 39)) ? 39 : 38;
    e  = p + ea - eb - 39 + 127;
    if (e >= 255) return {4'b0010, s, 8'hFF, 23'd0};
    sh = (e >= 1) ? (p - 23) : (p - 23 + (1 - e));
    if (sh >= 64) begin
      kept = 0; up = 0; inex = 1;
    end else begin
      kept = q >> sh;
      rb   = q & ((64'd1 << sh) - 1);
      half = 64'd1 << (sh - 1);
      inex = (rb != 0) || (rm != 0);
      up   = (rb > half) || ((rb == half) && ((rm != 0) || kept[0]));
    end
    mag = (e >= 1) ? ((longint'(e - 1) << 23) + kept + longint'(up)) : (kept + longint'(up));
    ovf = (mag >= (64'd255 << 23));
    if (ovf) mag = 64'd255 << 23;
    return {2'b00, ovf, (e < 1) && inex, s, mag[30:0]};
  endfunction

  // drives one operation; inject>0 raises a second start at that cycle while busy
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input int inject, input string req);
    logic [35:0] exp_v, act_v;
    logic [31:0] held;
    int n;
    exp_v = ref_div(a, b);
    @(negedge clk);
    a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R2 busy after start", {35'd0, busy_o}, 36'd1);
    n = 0;
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
      if (inject > 0 && n == inject) begin
        a_i = 32'h3F80_0000; b_i = 32'h4000_0000; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    check(n == 27, "R3 latency", 36'(n), 36'd27);
    act_v = {flag_invalid_o, flag_divzero_o, flag_overflow_o, flag_underflow_o, quot_o};
    check(act_v === exp_v, req, act_v, exp_v);
    held = quot_o;
    @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b0, "R2 R3 single done, no queued op",
          {34'd0, done_o, busy_o}, 36'd0);
    @(negedge clk);
    check(quot_o === held, "R12 result held", {4'd0, quot_o}, {4'd0, held});
  endtask

  function automatic logic [31:0] rand_op();
    int sel;
    logic [7:0] e;
    sel = int'($urandom % 20);
    case (sel)
      0: return {$urandom_range(1, 0) == 1, 31'd0};
      1: return {$urandom_range(1, 0) == 1, 8'hFF, 23'd0};
      2: return {1'b0, 8'hFF, 23'($urandom | 1)};
      3, 4: return {$urandom_range(1, 0) == 1, 8'd0, 23'($urandom | 1)};
      5, 6, 7: begin
        e = 8'($urandom_range(254, 1));
        return {$urandom_range(1, 0) == 1, e, 23'($urandom)};
      end
      default: begin
        e = 8'($urandom_range(140, 114));
        return {$urandom_range(1, 0) == 1, e, 23'($urandom)};
      end
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({busy_o, done_o, quot_o, flag_invalid_o, flag_divzero_o, flag_overflow_o, flag_underflow_o} === '0,
          "R11 reset state", {busy_o, done_o, quot_o[29:0], flag_invalid_o, flag_divzero_o, flag_overflow_o, flag_underflow_o}, 36'd0);

    run_op(32'h40C0_0000, 32'h4040_0000, 0, "R4 6/3");
    check(quot_o === 32'h4000_0000, "R4 6/3 exact", {4'd0, quot_o}, 36'h0_4000_0000);
    run_op(32'h3F80_0000, 32'h4040_0000, 0, "R4 1/3");
    check(quot_o === 32'h3EAA_AAAB, "R4 1/3 rounding", {4'd0, quot_o}, 36'h0_3EAA_AAAB);
    run_op(32'hC0C0_0000, 32'h4040_0000, 0, "R1 negative/positive");
    check(quot_o === 32'hC000_0000, "R1 sign xor", {4'd0, quot_o}, 36'h0_C000_0000);
    run_op(32'h4120_0000, 32'h4040_0000, 7, "R2 start while busy ignored");
    run_op(32'h7FC1_2345, 32'h3F80_0000, 0, "R6 NaN input");
    run_op(32'h0000_0000, 32'h8000_0000, 0, "R6 zero over zero");
    run_op(32'h7F80_0000, 32'hFF80_0000, 0, "R6 inf over inf");
    run_op(32'hBF80_0000, 32'h0000_0000, 0, "R7 divide by zero");
    check(quot_o === 32'hFF80_0000 && flag_divzero_o, "R7 negative infinity",
          {3'd0, flag_divzero_o, quot_o}, 36'h1_FF80_0000);
    run_op(32'h7F80_0000, 32'hC000_0000, 0, "R8 inf over finite");
    run_op(32'h8000_0000, 32'h4000_0000, 0, "R8 zero over finite");
    run_op(32'h3F80_0000, 32'h7F80_0000, 0, "R8 finite over inf");
    run_op(32'h7F7F_FFFF, 32'h3F00_0000, 0, "R9 overflow");
    check(flag_overflow_o === 1'b1, "R9 overflow flag", {35'd0, flag_overflow_o}, 36'd1);
    run_op(32'h0080_0000, 32'h4000_0000, 0, "R10 exact subnormal");
    check(quot_o === 32'h0040_0000 && !flag_underflow_o, "R10 exact subnormal no flag",
          {3'd0, flag_underflow_o, quot_o}, 36'h0_0040_0000);
    run_op(32'h0000_0001, 32'h4000_0000, 0, "R10 tie to zero");
    check(quot_o === 32'h0 && flag_underflow_o, "R10 tie rounds to even zero",
          {3'd0, flag_underflow_o, quot_o}, 36'h1_0000_0000);
    run_op(32'h0000_0003, 32'h4000_0000, 0, "R10 tie up to even");
    check(quot_o === 32'h0000_0002, "R10 1.5 min subnormal", {4'd0, quot_o}, 36'h0_0000_0002);
    run_op(32'h0080_0000, 32'h7F00_0000, 0, "R10 far below range");
    run_op(32'h0000_0005, 32'h3400_0000, 0, "R5 subnormal dividend");
    run_op(32'h3F80_0000, 32'h0000_0003, 0, "R5 subnormal divisor");
    run_op(32'h3FFF_FFFF, 32'h3F80_0001, 0, "R4 near one");

    for (int i = 0; i < 400; i++) begin
      run_op(rand_op(), rand_op(), 0, "R4 R5 R10 random operands");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule